// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches CPU accesses to a 32 KiB cartridge address space whose lower 16 KiB is a switchable window and whose upper 16 KiB is pinned to the last bank. Every access is turned into a 19-bit storage address: the bank number from an external banking latch times 16 KiB, plus the 14-bit offset inside the window. Writes into the switchable window are fed to a command sequencer. It recognises two unlock writes followed by a command, and then either programs one byte or erases one 4 KiB sector of a RAM-backed flash model reached through a storage-array port.

While an operation runs, the block owns the storage port and answers CPU reads with a status byte: bit 6 flips on every read and bit 7 is the inverse of the value the location will finally hold. Software polls until two successive reads agree and then sees real data. Writes to the upper half of the space are bank-latch writes. The sequencer ignores them, so software can move the latch between the steps of a sequence.

Top module: `flash_cmd_decoder`

## Requirements
- R1: With `cpu_addr[14]`=0 the storage address is `bank`×16384 + `cpu_addr[13:0]`. With `cpu_addr[14]`=1 it is 31×16384 + `cpu_addr[13:0]`. While idle, `cpu_rdata` returns the storage byte at that address.
- R2: The unlock pair is data 0xAA written to storage address 0x5555 (bank 1, offset 0x1555), then data 0x55 written to 0x2AAA (bank 0, offset 0x2AAA). The command byte after the pair is written to 0x5555.
- R3: Command 0xA0 arms programming. The next window write, at any bank and offset, makes exactly one storage write there, of the old byte ANDed with the written data.
- R4: Command 0x80, a second unlock pair, then data 0x30 written anywhere in a 4096-byte aligned sector sets every byte of that sector to 0xFF. Bytes outside the sector are left unchanged.
- R5: A window write with the wrong data or address for the current step returns the sequencer to idle, so the remaining steps of that sequence have no effect.
- R6: Writes with `cpu_addr[14]`=1 do not advance or reset the sequencer.
- R7: While busy, a read returns a status byte. Bit 7 is the inverse of bit 7 of the final value (0xFF for an erase, the written data for a program). Bit 6 is 0 on the first read of the operation and flips on each later read. Bits 5..0 are 0.
- R8: Busy starts in the cycle after the command write. It lasts PROG_CYCLES cycles (default 8) for a program and 4096 cycles for an erase. Storage writes happen only while busy. Reads after busy return storage data.
- R9: Window writes made while busy are ignored: they start no sequence and change no storage.
- R10: After reset the block is idle and makes no storage write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe, one cycle per read |
| cpu_addr | input | 15 | CPU address inside the cartridge space; bit 14 selects the fixed half |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data or busy status |
| bank | input | 5 | Current bank from the banking latch |
| mem_addr | output | 19 | Storage-array address |
| mem_we | output | 1 | Storage-array write enable |
| mem_wdata | output | 8 | Storage-array write data |
| mem_rdata | input | 8 | Storage-array read data, valid in the same cycle as `mem_addr` |

## Verification
The bench interleaves bank-latch writes between the unlock steps. A decoder that treated those writes as sequence breaks would never program. It also counts busy reads exactly, so an off-by-one in the busy counter, or an erase that ended early, shows up as a wrong count or as unerased bytes at the end of the sector. Programming a byte that already holds data exposes a design that overwrites instead of ANDing. A broken unlock followed by the rest of a valid tail catches a sequencer that resumes instead of falling back to idle. A full sequence issued while busy catches one that listens during an operation.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int FA_W   = 19;
  localparam int BANK_W = 5;
  localparam int OFF_W  = 14;
  localparam int DW     = 8;

  localparam logic [FA_W-1:0]   UNLOCK_A  = 19'h05555;
  localparam logic [FA_W-1:0]   UNLOCK_B  = 19'h02AAA;
  localparam logic [DW-1:0]     KEY_A     = 8'hAA;
  localparam logic [DW-1:0]     KEY_B     = 8'h55;
  localparam logic [DW-1:0]     CMD_PROG  = 8'hA0;
  localparam logic [DW-1:0]     CMD_ERASE = 8'h80;
  localparam logic [DW-1:0]     CMD_SECT  = 8'h30;
  localparam logic [BANK_W-1:0] FIXED_BANK = '1;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_ERA0, SQ_ERA1, SQ_ERA2, SQ_PARM
  } seq_t;

  typedef enum logic [1:0] {EN_IDLE, EN_PROG, EN_ERASE} eng_t;

  function automatic logic [FA_W-1:0] flash_addr(input logic [BANK_W-1:0] b,
                                                 input logic [OFF_W-1:0] off);
    return {b, off};
  endfunction

  function automatic logic [DW-1:0] program_merge(input logic [DW-1:0] old_v,
                                                  input logic [DW-1:0] new_v);
    return old_v & new_v;
  endfunction

  function automatic logic [DW-1:0] busy_status(input logic [DW-1:0] fin,
                                                input logic tog);
    return {~fin[DW-1], tog, {(DW-2){1'b0}}};
  endfunction
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            busy_i,
  input  logic [FA_W-1:0] fa_i,
  input  logic [DW-1:0]   data_i,
  output logic            start_prog_o,
  output logic            start_erase_o,
  output seq_t            state_o
);
  seq_t state, nxt;
  logic at_a, at_b;

  assign at_a = (fa_i == UNLOCK_A);
  assign at_b = (fa_i == UNLOCK_B);

  always_comb begin
    nxt = state;
    if (wr_i) begin
      nxt = SQ_IDLE;
      unique case (state)
        SQ_IDLE: if (at_a && data_i == KEY_A) nxt = SQ_UNL1;
        SQ_UNL1: if (at_b && data_i == KEY_B) nxt = SQ_UNL2;
        SQ_UNL2: begin
          if (at_a && data_i == CMD_PROG)  nxt = SQ_PARM;
          if (at_a && data_i == CMD_ERASE) nxt = SQ_ERA0;
        end
        SQ_ERA0: if (at_a && data_i == KEY_A) nxt = SQ_ERA1;
        SQ_ERA1: if (at_b && data_i == KEY_B) nxt = SQ_ERA2;
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  assign start_prog_o  = wr_i && (state == SQ_PARM);
  assign start_erase_o = wr_i && (state == SQ_ERA2) && (data_i == CMD_SECT);
  assign state_o       = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= nxt;
  end

  // R9: the sequencer never holds progress while an operation runs
  p_busy_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> state == SQ_IDLE);
  // R5: a wrong first step leaves the sequencer idle
  p_bad_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && state == SQ_IDLE && data_i != KEY_A) |=> state == SQ_IDLE);
endmodule

// File: rtl/fcd_engine.sv
module fcd_engine
  import fcd_pkg::*;
#(
  parameter int PROG_CYCLES = 8,
  parameter int SECTOR_BITS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_prog_i,
  input  logic            start_erase_i,
  input  logic [FA_W-1:0] tgt_addr_i,
  input  logic [DW-1:0]   tgt_data_i,
  input  logic            rd_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            busy_o,
  output logic [FA_W-1:0] addr_o,
  output logic            we_o,
  output logic [DW-1:0]   wdata_o,
  output logic [DW-1:0]   status_o
);
  localparam int SECTOR_BYTES = 1 << SECTOR_BITS;
  localparam int PC_W  = $clog2(PROG_CYCLES + 1);
  localparam int CNT_W = ((SECTOR_BITS > PC_W) ? SECTOR_BITS : PC_W) + 1;

  function automatic logic [FA_W-1:0] sector_base(input logic [FA_W-1:0] a);
    return {a[FA_W-1:SECTOR_BITS], {SECTOR_BITS{1'b0}}};
  endfunction

  function automatic logic [FA_W-1:0] sweep_addr(input logic [FA_W-1:0] base,
                                                 input logic [SECTOR_BITS-1:0] idx);
    return {base[FA_W-1:SECTOR_BITS], idx};
  endfunction

  eng_t             st;
  logic [CNT_W-1:0] cnt;
  logic [FA_W-1:0]  tgt;
  logic [DW-1:0]    fin;
  logic             tog;
  logic             op_last;

  assign op_last = ((st == EN_PROG)  && (cnt == CNT_W'(PROG_CYCLES - 1))) ||
                   ((st == EN_ERASE) && (cnt == CNT_W'(SECTOR_BYTES - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= EN_IDLE;
      cnt <= '0;
      tgt <= '0;
      fin <= '0;
      tog <= 1'b0;
    end else if (st == EN_IDLE) begin
      cnt <= '0;
      tog <= 1'b0;
      if (start_prog_i) begin
        st  <= EN_PROG;
        tgt <= tgt_addr_i;
        fin <= tgt_data_i;
      end else if (start_erase_i) begin
        st  <= EN_ERASE;
        tgt <= sector_base(tgt_addr_i);
        fin <= '1;
      end
    end else begin
      if (op_last) st <= EN_IDLE;
      cnt <= cnt + 1'b1;
      if (rd_i) tog <= ~tog;
    end
  end

  assign busy_o   = (st != EN_IDLE);
  assign addr_o   = (st == EN_ERASE) ? sweep_addr(tgt, cnt[SECTOR_BITS-1:0]) : tgt;
  assign we_o     = ((st == EN_PROG) && (cnt == '0)) || (st == EN_ERASE);
  assign wdata_o  = (st == EN_ERASE) ? '1 : program_merge(mem_rdata_i, fin);
  assign status_o = busy_status(fin, tog);

  // R8: program busy window never exceeds its length
  p_prog_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EN_PROG) |-> cnt < CNT_W'(PROG_CYCLES));
  // R8: the final busy cycle is followed by idle
  p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_last |=> st == EN_IDLE);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int PROG_CYCLES = 8,
  parameter int SECTOR_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [OFF_W:0]    cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  input  logic [BANK_W-1:0] bank,
  output logic [FA_W-1:0]   mem_addr,
  output logic              mem_we,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  logic            win_hit, wr_fire, busy;
  logic            start_prog, start_erase;
  logic [FA_W-1:0] cpu_fa, eng_addr;
  logic [DW-1:0]   eng_status;
  seq_t            seq_state;

  assign win_hit = ~cpu_addr[OFF_W];
  assign cpu_fa  = flash_addr(win_hit ? bank : FIXED_BANK, cpu_addr[OFF_W-1:0]);
  assign wr_fire = cpu_wr && win_hit && !busy;

  fcd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_fire), .busy_i(busy),
    .fa_i(cpu_fa), .data_i(cpu_wdata),
    .start_prog_o(start_prog), .start_erase_o(start_erase), .state_o(seq_state)
  );

  fcd_engine #(.PROG_CYCLES(PROG_CYCLES), .SECTOR_BITS(SECTOR_BITS)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_prog_i(start_prog), .start_erase_i(start_erase),
    .tgt_addr_i(cpu_fa), .tgt_data_i(cpu_wdata), .rd_i(cpu_rd),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .addr_o(eng_addr),
    .we_o(mem_we), .wdata_o(mem_wdata), .status_o(eng_status)
  );

  assign mem_addr  = busy ? eng_addr : cpu_fa;
  assign cpu_rdata = busy ? eng_status : mem_rdata;

  // R3: the program write lands one cycle after the arming write, merged by AND
  p_prog_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |=> mem_we && (mem_wdata == ($past(cpu_wdata) & mem_rdata)));
  // R4: an erase begins at the sector base with all ones
  p_erase_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_erase |=> mem_we && (mem_wdata == '1) && (mem_addr[SECTOR_BITS-1:0] == '0));
  // R8 / R10: storage writes only while busy
  p_we_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R6: latch-half writes leave the sequencer untouched
  p_latch_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[OFF_W]) |=> $stable(seq_state));
  // R7: back-to-back busy reads see bit 6 flip
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && busy) ##1 (cpu_rd && busy) |-> cpu_rdata[6] != $past(cpu_rdata[6]));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
  localparam int PROG_N = 8;
  localparam int SECT_N = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [14:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [4:0]  bank = '0;
  logic [18:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int checks = 0, fails = 0, we_cnt = 0, mem_ver = 0;
  bit done = 0;
  logic [7:0] fmem [int];
  logic [7:0] exp_q[$];
  logic [7:0] mask_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bank(bank), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mget(input int a);
    if (fmem.exists(a)) return fmem[a];
    return 8'hFF;
  endfunction

  function automatic int fa(input int b, input int off);
    return b * 16384 + off;
  endfunction

  always @(mem_addr or mem_ver) mem_rdata = mget(int'(mem_addr));

  always @(posedge clk) begin
    if (mem_we) begin
      fmem[int'(mem_addr)] = mem_wdata;
      we_cnt  <= we_cnt + 1;
      mem_ver <= mem_ver + 1;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp,
                       input logic [7:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    #2;
    if (cpu_rd && exp_q.size() > 0) begin
      logic [7:0] e, m;
      string t;
      e = exp_q.pop_front(); m = mask_q.pop_front(); t = tag_q.pop_front();
      if (m != 8'h00) check(t, cpu_rdata, e, m);
    end
  end

  task automatic wr(input int b, input int off, input logic [7:0] d);
    @(negedge clk);
    bank = 5'(b); cpu_addr = 15'(off); cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
  endtask

  task automatic latch(input int b);
    wr(b, 16'h4000 | b, 8'(b));
  endtask

  task automatic rd(input int b, input int off, input logic [7:0] e, input logic [7:0] m,
                    input string tag, output logic [7:0] v);
    @(negedge clk);
    exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(tag);
    bank = 5'(b); cpu_addr = 15'(off); cpu_wr = 1'b0; cpu_rd = 1'b1;
    #2 v = cpu_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic unlock(input bit with_latch);
    wr(1, 'h1555, 8'hAA);
    if (with_latch) latch(0);
    wr(0, 'h2AAA, 8'h55);
    if (with_latch) latch(1);
  endtask

  // poll until the final value appears; returns number of reads before it
  task automatic poll(input int b, input int off, input logic [7:0] fin, output int nb);
    logic [7:0] v;
    nb = 0;
    for (int k = 0; k < SECT_N + 64; k++) begin
      rd(b, off, 8'h00, 8'h00, "poll", v);
      if (v == fin) break;
      nb++;
    end
    rd(b, off, fin, 8'hFF, "R8 second equal read", v);
    idle();
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int nb, w0;
    fmem[fa(3, 'h0123)]  = 8'h3C;
    fmem[fa(31, 'h0010)] = 8'h77;
    fmem[fa(2, 'h0456)]  = 8'hF0;
    fmem[fa(5, 'h1000)]  = 8'h00;
    fmem[fa(5, 'h1FFF)]  = 8'h12;
    fmem[fa(5, 'h0FFF)]  = 8'h55;
    fmem[fa(5, 'h2000)]  = 8'h66;
    fmem[fa(4, 'h0010)]  = 8'hC3;
    mem_ver = 1;

    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 no storage write in reset", {7'b0, mem_we}, 8'h00, 8'hFF);
    rst_n = 1'b1;
    idle();
    check_int("R10 no writes after reset", we_cnt, 0);

    // R1: window and fixed-half mapping
    rd(3, 'h0123, 8'h3C, 8'hFF, "R1 window read", v);
    rd(9, 'h4010, 8'h77, 8'hFF, "R1 fixed half maps bank 31", v);
    idle();

    // R2 / R3 / R7 / R8: program one byte
    w0 = we_cnt;
    unlock(0);
    wr(1, 'h1555, 8'hA0);
    wr(2, 'h0456, 8'h3C);
    rd(2, 'h0456, 8'h80, 8'hFF, "R7 first busy status", v);
    rd(2, 'h0456, 8'hC0, 8'hFF, "R7 second busy status toggles", v);
    poll(2, 'h0456, 8'h30, nb);
    check_int("R8 program busy length", nb + 2, PROG_N);
    check_int("R3 exactly one storage write", we_cnt - w0, 1);
    check("R3 stored old AND new", mget(fa(2, 'h0456)), 8'h30, 8'hFF);
    check("R2 unlock pair accepted", mget(fa(2, 'h0456)), 8'h30, 8'hFF);

    // R6: latch writes between every step
    unlock(1);
    latch(1);
    wr(1, 'h1555, 8'hA0);
    latch(7);
    wr(7, 'h3FFF, 8'hA5);
    poll(7, 'h3FFF, 8'hA5, nb);
    check("R6 program through latch writes", mget(fa(7, 'h3FFF)), 8'hA5, 8'hFF);

    // R5: wrong data, then wrong address
    w0 = we_cnt;
    wr(1, 'h1555, 8'hAA);
    wr(0, 'h2AAA, 8'h54);
    wr(1, 'h1555, 8'hA0);
    wr(4, 'h0010, 8'h00);
    rd(4, 'h0010, 8'hC3, 8'hFF, "R5 bad data aborts", v);
    wr(1, 'h1554, 8'hAA);
    wr(0, 'h2AAA, 8'h55);
    wr(1, 'h1555, 8'hA0);
    wr(4, 'h0010, 8'h00);
    rd(4, 'h0010, 8'hC3, 8'hFF, "R5 bad address aborts", v);
    idle();
    check_int("R5 no storage writes", we_cnt - w0, 0);

    // R9: full sequence during busy is ignored
    w0 = we_cnt;
    unlock(0);
    wr(1, 'h1555, 8'hA0);
    wr(3, 'h0123, 8'h0F);
    unlock(0);
    wr(1, 'h1555, 8'hA0);
    wr(6, 'h0020, 8'h00);
    poll(3, 'h0123, 8'h0C, nb);
    rd(6, 'h0020, 8'hFF, 8'hFF, "R9 busy-time sequence ignored", v);
    idle();
    check_int("R9 single write only", we_cnt - w0, 1);

    // R4 / R7 / R8: sector erase via offset 0x1000
    w0 = we_cnt;
    unlock(0);
    wr(1, 'h1555, 8'h80);
    unlock(0);
    wr(5, 'h1000, 8'h30);
    rd(5, 'h1000, 8'h00, 8'hFF, "R7 erase busy status", v);
    rd(5, 'h1000, 8'h40, 8'hFF, "R7 erase status toggles", v);
    poll(5, 'h1000, 8'hFF, nb);
    check_int("R8 erase busy length", nb + 2, SECT_N);
    check_int("R4 erase write count", we_cnt - w0, SECT_N);
    rd(5, 'h1FFF, 8'hFF, 8'hFF, "R4 sector end erased", v);
    rd(5, 'h0FFF, 8'h55, 8'hFF, "R4 byte below sector kept", v);
    rd(5, 'h2000, 8'h66, 8'hFF, "R4 byte above sector kept", v);
    rd(31, 'h4010, 8'h77, 8'hFF, "R1 fixed half after erase", v);
    idle();
    repeat (4) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule